// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block chooses one exception among the pending requests of a processor core and produces, one clock later, everything the core needs to enter the handler. That is the return address for the link register of the new mode, the status word to be saved, the new status word, and the vector address to fetch from. The link value depends on both the exception type and the instruction-set state (32-bit or 16-bit compact). The new status word carries the target mode code, forces 32-bit state and sets the interrupt-disable flags.

A data abort that arrives together with an enabled fast interrupt is entered first. In the cycle that follows, the block chains straight into the fast-interrupt handler. It saves the abort handler's entry state, so a normal return from the fast interrupt resumes the abort handler at its first instruction. The return path is independent of entry. The block takes the banked link value, the saved status word and the exception type, and produces the resume PC and the restored status word in one registered step.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Exception type codes on `entry_kind_o` and `ret_kind_i` are: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. When several requests are pending, the winner is chosen in the order reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt. A fast interrupt is considered only when status bit 6 is 0, and a normal interrupt only when status bit 7 is 0.
- R2: The vector address on entry is `VEC_BASE` plus four times the type code (0x00, 0x04, 0x08, 0x0C, 0x10, 0x18, 0x1C with the default base).
- R3: Bits 4:0 of the new status word hold the target mode: supervisor 10011 for reset and software interrupt, undefined 11011, abort 10111 for both aborts, interrupt 10010, fast interrupt 10001.
- R4: In 32-bit state (`thumb_i`=0) the link value is the PC plus 4, except for data abort (plus 8) and reset (plus 0).
- R5: In 16-bit state the link value is the PC plus 2 for undefined and software interrupt, plus 4 for prefetch abort and both interrupts, plus 8 for data abort, and plus 0 for reset.
- R6: On an entry taken from the inputs, the saved status word equals `cpsr_i` of the cycle in which the request was seen.
- R7: The new status word equals the old one with bit 5 cleared and bit 7 set. Bit 6 is also set for reset and fast interrupt, and left unchanged for the other entries. All bits other than 7:0 pass through unchanged.
- R8: When a data abort wins while a fast interrupt is pending and status bit 6 is 0, the next cycle produces a fast-interrupt entry without any further request. That entry uses the abort vector as PC in 32-bit state (link = abort vector + 4) and takes the abort entry's new status word as its saved status. Other inputs are ignored in that cycle.
- R9: A reset request present in the chaining cycle overrides the pending chain and produces a reset entry from the inputs.
- R10: When `ret_i` is high, the next cycle raises `ret_valid_o` with `ret_pc_o` = `ret_lr_i` minus 4 (prefetch abort, both interrupts), minus 8 (data abort) or minus 0 (other types), and `ret_cpsr_o` = `ret_spsr_i`. Return outputs hold otherwise.
- R11: During reset both valid outputs and all data outputs are zero.
- R12: An entry appears exactly one cycle after the request is seen. A cycle with no enabled request and no pending chain produces no entry, and the entry data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| cpsr_i | input | 32 | Current status word |
| thumb_i | input | 1 | 1 = 16-bit compact state |
| req_reset_i | input | 1 | Reset exception request |
| req_dabt_i | input | 1 | Data abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_und_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| ret_i | input | 1 | Exception return strobe |
| ret_kind_i | input | 3 | Type code of the exception being left |
| ret_lr_i | input | 32 | Banked link value |
| ret_spsr_i | input | 32 | Banked saved status word |
| entry_valid_o | output | 1 | Entry produced this cycle |
| entry_kind_o | output | 3 | Type code of the entry |
| vector_o | output | 32 | Handler vector address |
| lr_o | output | 32 | Link register value |
| spsr_o | output | 32 | Status word to save |
| cpsr_o | output | 32 | New status word |
| ret_valid_o | output | 1 | Return result valid |
| ret_pc_o | output | 32 | Resume PC |
| ret_cpsr_o | output | 32 | Restored status word |

## Verification
The hardest situation to reach is the abort-to-fast-interrupt chain. It needs a data abort and an enabled fast interrupt in the same cycle, and it must be checked both with and without a reset request landing in the chaining cycle. Directed sequences drive each of these combinations. A long random phase then raises several requests at a time with random mask bits, so chains also start from 16-bit state and under other pending requests. A behavioural model in the bench predicts every output on every clock, including the held values between entries.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int DW    = 32;
  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_UND   = 3'd1,
    EK_SWI   = 3'd2,
    EK_PABT  = 3'd3,
    EK_DABT  = 3'd4,
    EK_IRQ   = 3'd6,
    EK_FIQ   = 3'd7
  } exc_kind_e;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  function automatic logic [4:0] mode_of(exc_kind_e k);
    case (k)
      EK_FIQ:          return MODE_FIQ;
      EK_IRQ:          return MODE_IRQ;
      EK_PABT, EK_DABT: return MODE_ABT;
      EK_UND:          return MODE_UND;
      default:         return MODE_SVC;
    endcase
  endfunction

  // Link offset added to the PC on entry.
  function automatic word_t link_off(exc_kind_e k, logic thumb);
    case (k)
      EK_UND, EK_SWI:          return thumb ? word_t'(2) : word_t'(4);
      EK_PABT, EK_IRQ, EK_FIQ: return word_t'(4);
      EK_DABT:                 return word_t'(8);
      default:                 return word_t'(0);
    endcase
  endfunction

  // Offset removed from the banked link value on return.
  function automatic word_t unwind_off(logic [2:0] k);
    case (k)
      3'd3, 3'd6, 3'd7: return word_t'(4);
      3'd4:             return word_t'(8);
      default:          return word_t'(0);
    endcase
  endfunction

  function automatic word_t enter_status(word_t st, exc_kind_e k);
    word_t n;
    n          = st;
    n[4:0]     = mode_of(k);
    n[BIT_T]   = 1'b0;
    n[BIT_I]   = 1'b1;
    if (k == EK_RESET || k == EK_FIQ) n[BIT_F] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      req_reset,
  input  logic      req_dabt,
  input  logic      req_fiq,
  input  logic      req_irq,
  input  logic      req_pabt,
  input  logic      req_und,
  input  logic      req_swi,
  input  logic      fiq_masked,
  input  logic      irq_masked,
  output logic      take,
  output exc_kind_e kind
);
  always_comb begin
    take = 1'b1;
    kind = EK_RESET;
    if (req_reset)                    kind = EK_RESET;
    else if (req_dabt)                kind = EK_DABT;
    else if (req_fiq && !fiq_masked)  kind = EK_FIQ;
    else if (req_irq && !irq_masked)  kind = EK_IRQ;
    else if (req_pabt)                kind = EK_PABT;
    else if (req_und)                 kind = EK_UND;
    else if (req_swi)                 kind = EK_SWI;
    else                              take = 1'b0;
  end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  exc_kind_e kind,
  input  word_t     pc,
  input  word_t     status,
  input  logic      thumb,
  output word_t     lr,
  output word_t     saved,
  output word_t     new_status,
  output word_t     vector
);
  always_comb begin
    lr         = pc + link_off(kind, thumb);
    saved      = status;
    new_status = enter_status(status, kind);
    vector     = VEC_BASE + {27'd0, kind, 2'b00};
  end
endmodule

// File: rtl/exc_unwind.sv
module exc_unwind
  import exc_pkg::*;
(
  input  logic [2:0] kind,
  input  word_t      link,
  output word_t      resume_pc
);
  always_comb resume_pc = link - unwind_off(kind);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc_i,
  input  logic [31:0] cpsr_i,
  input  logic        thumb_i,
  input  logic        req_reset_i,
  input  logic        req_dabt_i,
  input  logic        req_fiq_i,
  input  logic        req_irq_i,
  input  logic        req_pabt_i,
  input  logic        req_und_i,
  input  logic        req_swi_i,
  input  logic        ret_i,
  input  logic [2:0]  ret_kind_i,
  input  logic [31:0] ret_lr_i,
  input  logic [31:0] ret_spsr_i,
  output logic        entry_valid_o,
  output logic [2:0]  entry_kind_o,
  output logic [31:0] vector_o,
  output logic [31:0] lr_o,
  output logic [31:0] spsr_o,
  output logic [31:0] cpsr_o,
  output logic        ret_valid_o,
  output logic [31:0] ret_pc_o,
  output logic [31:0] ret_cpsr_o
);
  logic      arb_take;
  exc_kind_e arb_kind;
  logic      chain_q;
  logic      chain_go;
  logic      take;
  logic      chain_start;
  exc_kind_e fr_kind;
  word_t     fr_pc, fr_status;
  logic      fr_thumb;
  word_t     fr_lr, fr_saved, fr_new, fr_vec;
  word_t     resume_pc;

  exc_arbiter u_arb (
    .req_reset (req_reset_i),
    .req_dabt  (req_dabt_i),
    .req_fiq   (req_fiq_i),
    .req_irq   (req_irq_i),
    .req_pabt  (req_pabt_i),
    .req_und   (req_und_i),
    .req_swi   (req_swi_i),
    .fiq_masked(cpsr_i[BIT_F]),
    .irq_masked(cpsr_i[BIT_I]),
    .take      (arb_take),
    .kind      (arb_kind)
  );

  // Chained entry takes over unless reset is requested in that cycle.
  assign chain_go    = chain_q && !req_reset_i;
  assign take        = chain_go || arb_take;
  assign chain_start = !chain_go && arb_take && (arb_kind == EK_DABT)
                       && req_fiq_i && !cpsr_i[BIT_F];

  always_comb begin
    if (chain_go) begin
      fr_kind   = EK_FIQ;
      fr_pc     = vector_o;
      fr_status = cpsr_o;
      fr_thumb  = 1'b0;
    end else begin
      fr_kind   = arb_kind;
      fr_pc     = pc_i;
      fr_status = cpsr_i;
      fr_thumb  = thumb_i;
    end
  end

  exc_frame #(.VEC_BASE(VEC_BASE)) u_frame (
    .kind      (fr_kind),
    .pc        (fr_pc),
    .status    (fr_status),
    .thumb     (fr_thumb),
    .lr        (fr_lr),
    .saved     (fr_saved),
    .new_status(fr_new),
    .vector    (fr_vec)
  );

  exc_unwind u_unwind (
    .kind     (ret_kind_i),
    .link     (ret_lr_i),
    .resume_pc(resume_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid_o <= 1'b0;
      entry_kind_o  <= 3'd0;
      vector_o      <= '0;
      lr_o          <= '0;
      spsr_o        <= '0;
      cpsr_o        <= '0;
      chain_q       <= 1'b0;
    end else begin
      entry_valid_o <= take;
      chain_q       <= chain_start;
      if (take) begin
        entry_kind_o <= fr_kind;
        vector_o     <= fr_vec;
        lr_o         <= fr_lr;
        spsr_o       <= fr_saved;
        cpsr_o       <= fr_new;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid_o <= 1'b0;
      ret_pc_o    <= '0;
      ret_cpsr_o  <= '0;
    end else begin
      ret_valid_o <= ret_i;
      if (ret_i) begin
        ret_pc_o   <= resume_pc;
        ret_cpsr_o <= ret_spsr_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_valid_o,
  input logic [2:0]  entry_kind_o,
  input logic [31:0] vector_o,
  input logic [31:0] lr_o,
  input logic [31:0] spsr_o,
  input logic [31:0] cpsr_o,
  input logic [31:0] cpsr_i,
  input logic        req_reset_i,
  input logic        ret_valid_o,
  input logic [31:0] ret_cpsr_o,
  input logic [31:0] ret_spsr_i,
  input logic        chain_q
);
  // R7
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid_o |-> (cpsr_o[7] && !cpsr_o[5]));

  // R3
  fiq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && entry_kind_o == 3'd7) |-> (cpsr_o[4:0] == 5'b10001));

  // R1
  fiq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && entry_kind_o == 3'd7 && !$past(chain_q)) |-> !$past(cpsr_i[6]));

  // R6
  saved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid_o && !$past(chain_q)) |-> (spsr_o == $past(cpsr_i)));

  // R8
  chain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && !req_reset_i) |=> (entry_valid_o && entry_kind_o == 3'd7
      && lr_o == $past(vector_o) + 32'd4 && spsr_o == $past(cpsr_o)));

  // R9
  chain_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && req_reset_i) |=> (entry_valid_o && entry_kind_o == 3'd0));

  // R10
  ret_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_o |-> (ret_cpsr_o == $past(ret_spsr_i)));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .entry_valid_o(entry_valid_o),
  .entry_kind_o (entry_kind_o),
  .vector_o     (vector_o),
  .lr_o         (lr_o),
  .spsr_o       (spsr_o),
  .cpsr_o       (cpsr_o),
  .cpsr_i       (cpsr_i),
  .req_reset_i  (req_reset_i),
  .ret_valid_o  (ret_valid_o),
  .ret_cpsr_o   (ret_cpsr_o),
  .ret_spsr_i   (ret_spsr_i),
  .chain_q      (chain_q)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc_i = 0, cpsr_i = 0;
  logic thumb_i = 0;
  logic req_reset_i = 0, req_dabt_i = 0, req_fiq_i = 0, req_irq_i = 0;
  logic req_pabt_i = 0, req_und_i = 0, req_swi_i = 0;
  logic ret_i = 0;
  logic [2:0] ret_kind_i = 0;
  logic [31:0] ret_lr_i = 0, ret_spsr_i = 0;
  logic entry_valid_o, ret_valid_o;
  logic [2:0] entry_kind_o;
  logic [31:0] vector_o, lr_o, spsr_o, cpsr_o, ret_pc_o, ret_cpsr_o;

  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (.*);

  // Reference model state
  bit          m_valid, m_chain, m_rvalid;
  int          m_kind;
  logic [31:0] m_vec, m_lr, m_spsr, m_cpsr, m_rpc, m_rcpsr;
  string       m_tag;

  function automatic int pick_mode(int k);
    if (k == 7) return 5'b10001;
    if (k == 6) return 5'b10010;
    if (k == 3 || k == 4) return 5'b10111;
    if (k == 1) return 5'b11011;
    return 5'b10011;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_chain = 0; m_rvalid = 0; m_kind = 0;
      m_vec = 0; m_lr = 0; m_spsr = 0; m_cpsr = 0; m_rpc = 0; m_rcpsr = 0;
      m_tag = "R11";
    end else begin
      int k; logic [31:0] base, st, nst; bit th; int add; bit from_chain;
      k = -1; from_chain = 0; base = pc_i; st = cpsr_i; th = thumb_i; m_tag = "R1";
      if (m_chain && !req_reset_i) begin
        k = 7; base = m_vec; st = m_cpsr; th = 0; from_chain = 1; m_tag = "R8";
      end else if (req_reset_i) begin
        k = 0; if (m_chain) m_tag = "R9";
      end else if (req_dabt_i) k = 4;
      else if (req_fiq_i && cpsr_i[6] == 0) k = 7;
      else if (req_irq_i && cpsr_i[7] == 0) k = 6;
      else if (req_pabt_i) k = 3;
      else if (req_und_i) k = 1;
      else if (req_swi_i) k = 2;
      m_chain = (!from_chain && k == 4 && req_fiq_i && cpsr_i[6] == 0);
      m_valid = (k >= 0);
      if (k >= 0) begin
        case (k)
          0: add = 0;
          1, 2: add = th ? 2 : 4;
          4: add = 8;
          default: add = 4;
        endcase
        nst = st;
        nst[4:0] = pick_mode(k);
        nst[5] = 0; nst[7] = 1;
        if (k == 0 || k == 7) nst[6] = 1;
        m_kind = k; m_vec = 32'(k * 4); m_lr = base + 32'(add);
        m_spsr = st; m_cpsr = nst;
      end
      m_rvalid = ret_i;
      if (ret_i) begin
        int sub;
        sub = (ret_kind_i == 4) ? 8 : (ret_kind_i == 3 || ret_kind_i >= 6) ? 4 : 0;
        m_rpc = ret_lr_i - 32'(sub); m_rcpsr = ret_spsr_i;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!finished) begin
      string t;
      t = rst_n ? m_tag : "R11";
      chk(entry_valid_o == m_valid, rst_n ? "R12" : "R11", "entry_valid", 32'(entry_valid_o), 32'(m_valid));
      chk(int'(entry_kind_o) == m_kind, t, "kind", 32'(entry_kind_o), 32'(m_kind));
      chk(vector_o == m_vec, rst_n ? "R2" : "R11", "vector", vector_o, m_vec);
      chk(cpsr_o[4:0] == m_cpsr[4:0], rst_n ? "R3" : "R11", "mode", 32'(cpsr_o[4:0]), 32'(m_cpsr[4:0]));
      chk(lr_o == m_lr, !rst_n ? "R11" : (thumb_i ? "R5" : "R4"), "link", lr_o, m_lr);
      chk(spsr_o == m_spsr, rst_n ? "R6" : "R11", "saved", spsr_o, m_spsr);
      chk(cpsr_o == m_cpsr, rst_n ? "R7" : "R11", "status", cpsr_o, m_cpsr);
      chk(ret_valid_o == m_rvalid && ret_pc_o == m_rpc && ret_cpsr_o == m_rcpsr,
          rst_n ? "R10" : "R11", "return", ret_pc_o, m_rpc);
    end
  end

  task automatic idle();
    {req_reset_i, req_dabt_i, req_fiq_i, req_irq_i, req_pabt_i, req_und_i, req_swi_i} = '0;
    ret_i = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R1 R4 R5 single requests in both states
    for (int th = 0; th < 2; th++) begin
      for (int r = 0; r < 7; r++) begin
        @(negedge clk);
        idle();
        thumb_i = th[0]; pc_i = 32'h1000 + 32'(r * 16); cpsr_i = 32'hA000_0010 | (th ? 32'h20 : 0);
        case (r)
          0: req_reset_i = 1; 1: req_dabt_i = 1; 2: req_fiq_i = 1; 3: req_irq_i = 1;
          4: req_pabt_i = 1; 5: req_und_i = 1; default: req_swi_i = 1;
        endcase
      end
    end
    @(negedge clk); idle();
    // R12 masked interrupts alone give nothing
    cpsr_i = 32'h0000_00D3; req_irq_i = 1; req_fiq_i = 1;
    @(negedge clk); idle();
    // R8 chain from 16-bit state
    cpsr_i = 32'h6000_0030; thumb_i = 1; pc_i = 32'h2000; req_dabt_i = 1; req_fiq_i = 1; req_und_i = 1;
    @(negedge clk); idle(); req_irq_i = 1; cpsr_i = 0;
    @(negedge clk); idle();
    // chain blocked by mask
    cpsr_i = 32'h0000_0050; thumb_i = 0; req_dabt_i = 1; req_fiq_i = 1;
    @(negedge clk); idle();
    // R9 reset in chain cycle
    cpsr_i = 32'h0000_0010; req_dabt_i = 1; req_fiq_i = 1;
    @(negedge clk); idle(); req_reset_i = 1; cpsr_i = 32'h0000_001F;
    @(negedge clk); idle();
    // all at once
    {req_reset_i, req_dabt_i, req_fiq_i, req_irq_i, req_pabt_i, req_und_i, req_swi_i} = '1;
    @(negedge clk); idle();
    // R10 returns of every code
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ret_i = 1; ret_kind_i = 3'(k); ret_lr_i = 32'h0000_0400 + 32'(k); ret_spsr_i = 32'hF000_0000 | 32'(k);
    end
    @(negedge clk); idle();
    step(2);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req_reset_i = ($urandom_range(0, 63) == 0);
      req_dabt_i  = ($urandom_range(0, 5) == 0);
      req_fiq_i   = ($urandom_range(0, 3) == 0);
      req_irq_i   = ($urandom_range(0, 3) == 0);
      req_pabt_i  = ($urandom_range(0, 5) == 0);
      req_und_i   = ($urandom_range(0, 5) == 0);
      req_swi_i   = ($urandom_range(0, 5) == 0);
      thumb_i     = $urandom_range(0, 1) == 1;
      cpsr_i      = $urandom();
      pc_i        = $urandom() & 32'hFFFF_FFFE;
      ret_i       = $urandom_range(0, 2) == 0;
      ret_kind_i  = 3'($urandom_range(0, 7));
      ret_lr_i    = $urandom();
      ret_spsr_i  = $urandom();
      if (i == 2000) rst_n = 0;
      if (i == 2003) rst_n = 1;
    end
    @(negedge clk); idle();
    step(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule